// File: doc/BRIEF.md
# Reference Divider with Binary Post-Scaler

This block produces the phase-comparison reference for two frequency synthesiser loops from a single input clock. A 12-bit programmable counter divides the input clock by a ratio M. A small binary counter follows it and provides four taps with periods of M, 2M, 4M and 8M input cycles. Each loop has its own 2-bit tap select. The auxiliary loop takes its tap with true polarity. The main loop takes its tap inverted. When both loops run from the same rate, one loop therefore sees a rising edge in the opposite half-period from the other loop.

Parallel inputs hold the ratio, the two selects and a 2-bit power mode. One power code places the block in standby. In standby every counter is cleared and both outputs are held low. A ratio written while the divider runs is held back until the current period ends, so no output period is ever cut short. The block carries no data stream, so there is no valid/ready handshake. All pins are plain levels, sampled on the rising clock edge.

Top module: `refdiv_top`

## Requirements
- R1: With a select of 2'b00 the output has a period of exactly M input cycles, for every M from 3 to 4095.
- R2: The divide-by-M tap is high for ceil(M/2) cycles and low for floor(M/2) cycles of each period, starting high at count zero.
- R3: Select codes 2'b01, 2'b10 and 2'b11 give periods of 2M, 4M and 8M cycles, each exactly half high.
- R4: The auxiliary select and the main select are independent. Changing one select never alters the other output.
- R5: The auxiliary output is the selected tap itself, and the main output is the inverse of its selected tap. With equal selects while running, main_ref_o equals the inverse of aux_ref_o.
- R6: The ratio is captured on the first running clock edge after reset or standby, and otherwise on the edge that ends a period (count M-1). A write made in the middle of a period has no effect on that period.
- R7: A ratio value of 0, 1 or 2 is treated as 3.
- R8: pwr_mode_i = 2'b11 is standby. One cycle after standby is seen, both outputs are low, and they stay low for as long as standby lasts. On release, counting restarts from count zero and tap zero.
- R9: An asynchronous active-low reset clears all counters and drives both outputs low.
- R10: Both outputs are registered. Each output reflects the counter state that was present one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input reference clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 12 | Divide ratio M (values below 3 act as 3) |
| aux_sel_i | input | 2 | Tap for the auxiliary loop: 00=M, 01=2M, 10=4M, 11=8M |
| main_sel_i | input | 2 | Tap for the main loop, same encoding |
| pwr_mode_i | input | 2 | Power control; 2'b11 = standby, any other value = run |
| aux_ref_o | output | 1 | Auxiliary comparison reference (true phase) |
| main_ref_o | output | 1 | Main comparison reference (inverted phase) |

## Verification
Odd, even, minimum, clamped and maximum ratios are measured on the divide-by-M tap. These separate an off-by-one in the terminal count from an error in the high-time rounding. One ratio is measured on every post-scaler tap, which shows whether each select code reaches the correct counter bit. The bench writes a new ratio in the middle of a period and inserts standby pulses. Together with random selects and ratios checked cycle by cycle against a bench model, these patterns expose a ratio captured too early, a restart that is not from zero, and a polarity or select crossed between the two loops.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int RATIO_W   = 12;
  localparam int SEL_W     = 2;
  localparam int NTAP      = 1 << SEL_W;
  localparam int POST_W    = NTAP - 1;
  localparam int MIN_RATIO = 3;

  typedef enum logic [1:0] {
    PWR_RUN0 = 2'b00,
    PWR_RUN1 = 2'b01,
    PWR_RUN2 = 2'b10,
    PWR_STBY = 2'b11
  } pwr_mode_e;

  // Lift any ratio below the minimum up to the minimum
  function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] r);
    return (r < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : r;
  endfunction

  // Number of high cycles within one divide-by-M period: ceil(M/2)
  function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] m);
    logic [RATIO_W:0] wide;
    wide = {1'b0, m} + {{RATIO_W{1'b0}}, 1'b1};
    return wide[RATIO_W:1];
  endfunction
endpackage

// File: rtl/refdiv_prescale.sv
module refdiv_prescale
  import refdiv_pkg::*;
#(
  parameter int W = RATIO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] ratio_i,
  output logic         tc_o,
  output logic         level_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] m_q;
  logic         load_q;
  logic [W-1:0] m_eff;
  logic [W-1:0] m_last;

  // A fresh start takes the ratio from the pins; otherwise the latched one
  always_comb begin
    m_eff   = load_q ? clamp_ratio(ratio_i) : m_q;
    m_last  = m_eff - W'(1);
    tc_o    = (cnt_q == m_last);
    level_o = (cnt_q < high_len(m_eff));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      m_q    <= W'(MIN_RATIO);
      load_q <= 1'b1;
    end else if (!run) begin
      cnt_q  <= '0;
      load_q <= 1'b1;
    end else begin
      load_q <= 1'b0;
      if (tc_o) begin
        cnt_q <= '0;
        m_q   <= clamp_ratio(ratio_i);
      end else begin
        cnt_q <= cnt_q + W'(1);
        m_q   <= m_eff;
      end
    end
  end
endmodule

// File: rtl/refdiv_postscale.sv
module refdiv_postscale
  import refdiv_pkg::*;
#(
  parameter int TAPS = NTAP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            adv,
  input  logic            base_i,
  output logic [TAPS-1:0] taps_o
);
  localparam int PW = TAPS - 1;

  logic [PW-1:0] bin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
    end else if (!run) begin
      bin_q <= '0;
    end else if (adv) begin
      bin_q <= bin_q + PW'(1);
    end
  end

  assign taps_o[0] = base_i;
  for (genvar g = 1; g < TAPS; g++) begin : g_tap
    assign taps_o[g] = bin_q[g-1];
  end
endmodule

// File: rtl/refdiv_tapsel.sv
module refdiv_tapsel
  import refdiv_pkg::*;
#(
  parameter int  SW     = SEL_W,
  parameter bit  INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SW-1:0]     sel_i,
  input  logic [(1<<SW)-1:0] taps_i,
  output logic              ref_o
);
  logic picked;

  always_comb begin
    picked = taps_i[sel_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_o <= 1'b0;
    end else if (!run) begin
      ref_o <= 1'b0;
    end else begin
      ref_o <= INVERT ? ~picked : picked;
    end
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [SEL_W-1:0]   aux_sel_i,
  input  logic [SEL_W-1:0]   main_sel_i,
  input  logic [1:0]         pwr_mode_i,
  output logic               aux_ref_o,
  output logic               main_ref_o
);
  logic            run;
  logic            tc;
  logic            base_lvl;
  logic [NTAP-1:0] taps;

  assign run = (pwr_mode_i != PWR_STBY);

  refdiv_prescale #(.W(RATIO_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .ratio_i (ratio_i),
    .tc_o    (tc),
    .level_o (base_lvl)
  );

  refdiv_postscale #(.TAPS(NTAP)) u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .adv    (tc),
    .base_i (base_lvl),
    .taps_o (taps)
  );

  refdiv_tapsel #(.SW(SEL_W), .INVERT(1'b0)) u_aux (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .sel_i  (aux_sel_i),
    .taps_i (taps),
    .ref_o  (aux_ref_o)
  );

  refdiv_tapsel #(.SW(SEL_W), .INVERT(1'b1)) u_main (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .sel_i  (main_sel_i),
    .taps_i (taps),
    .ref_o  (main_ref_o)
  );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
  import refdiv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [RATIO_W-1:0] ratio_i,
  input logic [SEL_W-1:0]   aux_sel_i,
  input logic [SEL_W-1:0]   main_sel_i,
  input logic [1:0]         pwr_mode_i,
  input logic               aux_ref_o,
  input logic               main_ref_o
);
  logic run;
  assign run = (pwr_mode_i != PWR_STBY);

  // R8
  stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_mode_i) == PWR_STBY) |-> (!aux_ref_o && !main_ref_o));

  // R5
  phase_opp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(pwr_mode_i) != PWR_STBY) &&
     ($past(aux_sel_i) == $past(main_sel_i))) |-> (main_ref_o == !aux_ref_o));

  // R2
  aux_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(aux_ref_o) && $past(rst_n) && $past(rst_n, 2) &&
     run && $past(run) && $past(run, 2) &&
     (aux_sel_i == $past(aux_sel_i)) && ($past(aux_sel_i) == $past(aux_sel_i, 2)))
    |=> aux_ref_o);

  // R2
  main_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(main_ref_o) && $past(rst_n) && $past(rst_n, 2) &&
     run && $past(run) && $past(run, 2) &&
     (main_sel_i == $past(main_sel_i)) && ($past(main_sel_i) == $past(main_sel_i, 2)))
    |=> !main_ref_o);
endmodule

bind refdiv_top refdiv_chk u_chk (.*);

// File: tb/sim_refdiv_top.sv
`timescale 1ns/1ps
module sim_refdiv_top;
  localparam int RW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ratio = 12'd5;
  logic [1:0]    asel = 2'b00;
  logic [1:0]    msel = 2'b00;
  logic [1:0]    pwr = 2'b00;
  logic          aux_o, main_o;

  int    n_chk = 0;
  int    n_err = 0;
  int    cycles = 0;
  string cur_tag = "R9";

  always #5 clk = ~clk;

  refdiv_top u0 (
    .clk(clk), .rst_n(rst_n), .ratio_i(ratio), .aux_sel_i(asel),
    .main_sel_i(msel), .pwr_mode_i(pwr), .aux_ref_o(aux_o), .main_ref_o(main_o)
  );

  function automatic int clampm(input int r);
    return (r < 3) ? 3 : r;
  endfunction

  // Tap value from count c, ratio m, post-scale count p and select s
  function automatic logic tapv(input int c, input int m, input int p, input int s);
    if (s == 0) return (c < (m + 1) / 2);
    return ((p >> (s - 1)) & 1) != 0;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // Bench reference model, written from the requirements
  int   mc, mm, mp;
  bit   ld;
  logic ea, em;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc <= 0; mp <= 0; mm <= 3; ld <= 1'b1; ea <= 1'b0; em <= 1'b0;
    end else if (pwr == 2'b11) begin
      mc <= 0; mp <= 0; ld <= 1'b1; ea <= 1'b0; em <= 1'b0;
    end else begin
      int m;
      m = ld ? clampm(int'(ratio)) : mm;
      ea <= tapv(mc, m, mp, int'(asel));
      em <= ~tapv(mc, m, mp, int'(msel));
      ld <= 1'b0;
      if (mc == m - 1) begin
        mc <= 0; mp <= (mp + 1) % 8; mm <= clampm(int'(ratio));
      end else begin
        mc <= mc + 1; mm <= m;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    check({cur_tag, " aux model"}, int'(aux_o), int'(ea));
    check({cur_tag, " main model"}, int'(main_o), int'(em));
    if (cycles > 150000) begin
      n_err++;
      $display("FAIL watchdog: got %0d expected below %0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic measure(input string tag, input int exp_hi, input int exp_lo);
    int hi = 0;
    int lo = 0;
    int guard = 0;
    while (aux_o !== 1'b0 && guard < 40000) begin @(negedge clk); guard++; end
    while (aux_o !== 1'b1 && guard < 40000) begin @(negedge clk); guard++; end
    while (aux_o === 1'b1 && guard < 40000) begin @(negedge clk); hi++; guard++; end
    while (aux_o === 1'b0 && guard < 40000) begin @(negedge clk); lo++; guard++; end
    check({tag, " high"}, hi, exp_hi);
    check({tag, " low"}, lo, exp_lo);
  endtask

  task automatic setup(input int r, input int a, input int m);
    @(negedge clk);
    ratio = RW'(r); asel = 2'(a); msel = 2'(m);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 aux in reset", int'(aux_o), 0);
    check("R9 main in reset", int'(main_o), 0);
    rst_n = 1'b1;

    // R1 R2 odd ratio on the base tap
    cur_tag = "R1";
    setup(5, 0, 0);
    measure("R2 M=5", 3, 2);
    measure("R2 M=5 again", 3, 2);
    setup(8, 0, 0);
    measure("R1 M=8", 4, 4);
    setup(4095, 0, 0);
    measure("R1 M=4095", 2048, 2047);

    // R3 post-scaler taps
    cur_tag = "R3";
    setup(7, 1, 1);
    measure("R3 2M", 7, 7);
    setup(7, 2, 2);
    measure("R3 4M", 14, 14);
    setup(7, 3, 3);
    measure("R3 8M", 28, 28);

    // R7 clamp
    cur_tag = "R7";
    setup(1, 0, 0);
    measure("R7 ratio=1", 2, 1);
    setup(0, 0, 0);
    measure("R7 ratio=0", 2, 1);
    setup(2, 0, 0);
    measure("R7 ratio=2", 2, 1);

    // R5 equal selects give opposite outputs
    cur_tag = "R5";
    setup(9, 1, 1);
    repeat (20) begin
      @(negedge clk);
      check("R5 main inverse of aux", int'(main_o), int'(!aux_o));
    end

    // R6 mid-period ratio write
    cur_tag = "R6";
    setup(6, 0, 0);
    measure("R6 before write", 3, 3);
    while (aux_o !== 1'b1) @(negedge clk);
    @(negedge clk);
    ratio = 12'd12;
    begin
      int hi = 1;
      int lo = 0;
      while (aux_o === 1'b1) begin @(negedge clk); hi++; end
      while (aux_o === 1'b0) begin @(negedge clk); lo++; end
      check("R6 current period high kept", hi, 3);
      check("R6 current period low kept", lo, 3);
    end
    measure("R6 new ratio", 6, 6);

    // R8 standby and restart
    cur_tag = "R8";
    setup(5, 0, 1);
    repeat (7) @(negedge clk);
    pwr = 2'b11;
    @(negedge clk);
    check("R8 aux low in standby", int'(aux_o), 0);
    check("R8 main low in standby", int'(main_o), 0);
    repeat (6) @(negedge clk);
    check("R8 aux still low", int'(aux_o), 0);
    pwr = 2'b01;
    @(negedge clk);
    check("R8 restart aux at count zero", int'(aux_o), 1);
    check("R8 restart main tap zero inverted", int'(main_o), 1);
    measure("R8 period after restart", 3, 2);

    // R4 R10 random segments with independent selects
    cur_tag = "R4";
    for (int seg = 0; seg < 60; seg++) begin
      int pick;
      @(negedge clk);
      pick = int'($urandom_range(0, 9));
      if (pick == 0) ratio = RW'($urandom_range(0, 2));
      else if (pick == 1) ratio = RW'($urandom_range(100, 4095));
      else ratio = RW'($urandom_range(3, 40));
      asel = 2'($urandom_range(0, 3));
      msel = 2'($urandom_range(0, 3));
      pwr = ($urandom_range(0, 7) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      cur_tag = (seg % 2 == 0) ? "R4" : "R10";
      repeat ($urandom_range(5, 400)) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule